// File: doc/BRIEF.md
# Translation Cache with Hardware Table Walker

This block translates virtual page numbers into physical page numbers for a single address space. It keeps a small fully associative set of recent translations. A lookup that matches one of them is answered in the cycle after it is accepted. A lookup that finds no match starts a hardware walk over a three-level radix page table held in memory. The walk is a chain of dependent reads. The entry returned by each read selects the table that the next read goes to. The walk ends at a leaf, and the leaf's translation is written into the cache.

Software points the walker at a table set by writing a base register, and every such write empties the cache. Each leaf carries a write-protect flag. A store that reaches a protected page is answered with a fault rather than with a usable translation. A non-present entry found at any level also ends the walk with a fault. The memory port is a plain request/response pair with a fixed delay, and the block never has more than one read outstanding. While a walk is in progress, new lookups are held off.

Top module: `tlbw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: A lookup that matches a cached translation produces `rsp_valid` in the cycle right after acceptance, carrying the stored `rsp_ppn` and `rsp_wp`, and it issues no memory read.
- R3: A lookup that misses issues its reads in level order. Level 0 uses VPN bits [26:18], level 1 uses bits [17:9] and level 2 uses bits [8:0]. Each read address is `{table_ppn, index, 3'b000}`. The first table is the base register and each later table is the PPN of the previous entry.
- R4: Counting the request cycle as cycle 1, a miss that reaches a valid leaf is answered after 1 + 3 × MEM_LAT cycles. With MEM_LAT = 50 that is 151 cycles.
- R5: An entry is 64 bits wide. Bit 0 is present, bit 1 is write-protect (used only at the leaf), and bits [10 +: PPN_W] hold the PPN.
- R6: An entry with bit 0 clear at any level ends the walk immediately, with no further reads. The response then has `rsp_fault`=1 and `rsp_fault_wp`=0, `rsp_vpn` equal to the requested VPN, and nothing is cached.
- R7: A store (`req_store`=1) to a page whose write-protect bit is set answers `rsp_fault`=1 and `rsp_fault_wp`=1, on a hit or after a refill. Loads to such pages and stores to unprotected pages answer `rsp_fault`=0.
- R8: The cache holds 8 translations, replaced in round-robin order. A translation is installed only after the final read returns a present leaf.
- R9: `req_ready` is 0 while a walk is in progress, and at most one memory read is outstanding at any time.
- R10: Writing the base register (`bp_we`) invalidates every cached translation, and later walks start from the new base.
- R11: If the base register is written during a walk, that walk still completes and answers with the translation it was fetching, but the result is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bp_we | input | 1 | Base register write strobe; flushes the cache |
| bp_ppn | input | PPN_W | New base table PPN |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted (no walk running) |
| req_vpn | input | 27 | Virtual page number to translate |
| req_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ppn | output | PPN_W | Translated PPN (0 on a not-present fault) |
| rsp_wp | output | 1 | Page is write-protected |
| rsp_fault | output | 1 | Translation fault (not present, or store to a protected page) |
| rsp_fault_wp | output | 1 | Fault caused by write protection |
| rsp_vpn | output | 27 | VPN of this response (faulting VPN on a fault) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | PPN_W+12 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Table entry read back |

## Verification
A corrupted cached entry or a wrong round-robin pointer shows up on the next lookup of an affected page. Either the wrong PPN comes back one cycle after acceptance, or the response latency jumps between 1 and 151 cycles when the opposite was due. A wrong level counter or a wrong index slice changes the read count or the first read address within a single walk. A broken stale-walk flag shows only one lookup later, as a one-cycle answer where a fresh walk was expected.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    localparam int LEVELS      = 3;
    localparam int LVL_BITS    = 9;
    localparam int LVL_W       = 2;
    localparam int PTE_W       = 64;
    localparam int PTE_OFF_W   = 3;
    localparam int PTE_PRESENT = 0;
    localparam int PTE_WPROT   = 1;
    localparam int PTE_PPN_LSB = 10;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_WAIT = 1'b1
    } wk_state_e;
endpackage

// File: rtl/tlbw_store.sv
module tlbw_store #(
    parameter int N_ENT = 8,
    parameter int VPN_W = 27,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wp,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             ins_wp
);
    localparam int PTR_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        logic             wp;
    } ent_t;

    typedef struct packed {
        ent_t [N_ENT-1:0] ent;
        logic [PTR_W-1:0] vic;
    } st_t;

    st_t s_d, s_q;
    logic [N_ENT-1:0] match;
    logic [N_ENT-1:0] vld;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign vld[g]   = s_q.ent[g].v;
        assign match[g] = s_q.ent[g].v && (s_q.ent[g].vpn == lk_vpn);
    end

    assign lk_hit = |match;

    always_comb begin
        lk_ppn = '0;
        lk_wp  = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) begin
                lk_ppn = lk_ppn | s_q.ent[i].ppn;
                lk_wp  = lk_wp | s_q.ent[i].wp;
            end
        end
    end

    always_comb begin
        s_d = s_q;
        if (flush) begin
            for (int i = 0; i < N_ENT; i++) begin
                s_d.ent[i].v = 1'b0;
            end
        end else if (ins_en) begin
            s_d.ent[s_q.vic].v   = 1'b1;
            s_d.ent[s_q.vic].vpn = ins_vpn;
            s_d.ent[s_q.vic].ppn = ins_ppn;
            s_d.ent[s_q.vic].wp  = ins_wp;
            if (s_q.vic == PTR_W'(N_ENT - 1)) begin
                s_d.vic = '0;
            end else begin
                s_d.vic = s_q.vic + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // at most one slot may ever claim a lookup
    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // a base write leaves no slot usable on the next cycle
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));
endmodule

// File: rtl/tlbw_walker.sv
module tlbw_walker
    import tlbw_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int PPN_W  = 20,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VPN_W-1:0]  start_vpn,
    input  logic              start_store,
    input  logic [PPN_W-1:0]  base_ppn,
    input  logic              flush,
    output logic              busy,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic              done_np,
    output logic [PPN_W-1:0]  done_ppn,
    output logic              done_wp,
    output logic [VPN_W-1:0]  done_vpn,
    output logic              done_store,
    output logic              ins_en
);
    typedef struct packed {
        wk_state_e        st;
        logic [LVL_W-1:0] lvl;
        logic [VPN_W-1:0] vpn;
        logic             store;
        logic             stale;
    } st_t;

    st_t s_d, s_q;

    logic             pte_present;
    logic [PPN_W-1:0] pte_ppn;
    logic             pte_unused;

    assign pte_present = mem_rsp_data[PTE_PRESENT];
    assign pte_ppn     = mem_rsp_data[PTE_PPN_LSB +: PPN_W];
    assign pte_unused  = ^{mem_rsp_data[PTE_W-1:PTE_PPN_LSB+PPN_W],
                           mem_rsp_data[PTE_PPN_LSB-1:PTE_WPROT+1]};

    function automatic logic [LVL_BITS-1:0] lvl_idx(input logic [VPN_W-1:0] v,
                                                    input logic [LVL_W-1:0] l);
        logic [VPN_W-1:0] sh;
        sh = v >> (LVL_BITS * ((LEVELS - 1) - int'(l)));
        return sh[LVL_BITS-1:0];
    endfunction

    always_comb begin
        s_d           = s_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        done          = 1'b0;
        ins_en        = 1'b0;
        case (s_q.st)
            WK_IDLE: begin
                if (start) begin
                    mem_req_valid = 1'b1;
                    mem_req_addr  = {base_ppn, lvl_idx(start_vpn, '0), {PTE_OFF_W{1'b0}}};
                    s_d.st        = WK_WAIT;
                    s_d.lvl       = '0;
                    s_d.vpn       = start_vpn;
                    s_d.store     = start_store;
                    s_d.stale     = flush;
                end
            end
            default: begin
                if (flush) begin
                    s_d.stale = 1'b1;
                end
                if (mem_rsp_valid) begin
                    if (!pte_present) begin
                        done   = 1'b1;
                        s_d.st = WK_IDLE;
                    end else if (s_q.lvl == LVL_W'(LEVELS - 1)) begin
                        done   = 1'b1;
                        ins_en = !(s_q.stale || flush);
                        s_d.st = WK_IDLE;
                    end else begin
                        mem_req_valid = 1'b1;
                        mem_req_addr  = {pte_ppn, lvl_idx(s_q.vpn, s_q.lvl + 1'b1),
                                         {PTE_OFF_W{1'b0}}};
                        s_d.lvl       = s_q.lvl + 1'b1;
                    end
                end
            end
        endcase
    end

    assign busy       = (s_q.st == WK_WAIT);
    assign done_np    = !pte_present;
    assign done_ppn   = pte_ppn;
    assign done_wp    = mem_rsp_data[PTE_WPROT];
    assign done_vpn   = s_q.vpn;
    assign done_store = s_q.store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // no new read while the previous one has not returned
    assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |-> !mem_req_valid);

    // a missing entry ends the walk at once
    assert_np_ends_walk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_np) |=> !busy);
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
    import tlbw_pkg::*;
#(
    parameter int PPN_W = 20,
    parameter int N_ENT = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    bp_we,
    input  logic [PPN_W-1:0]                        bp_ppn,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic [LEVELS*LVL_BITS-1:0]              req_vpn,
    input  logic                                    req_store,
    output logic                                    rsp_valid,
    output logic [PPN_W-1:0]                        rsp_ppn,
    output logic                                    rsp_wp,
    output logic                                    rsp_fault,
    output logic                                    rsp_fault_wp,
    output logic [LEVELS*LVL_BITS-1:0]              rsp_vpn,
    output logic                                    mem_req_valid,
    output logic [PPN_W+LVL_BITS+PTE_OFF_W-1:0]     mem_req_addr,
    input  logic                                    mem_rsp_valid,
    input  logic [PTE_W-1:0]                        mem_rsp_data
);
    localparam int VPN_W  = LEVELS * LVL_BITS;
    localparam int ADDR_W = PPN_W + LVL_BITS + PTE_OFF_W;

    typedef struct packed {
        logic [PPN_W-1:0] bp;
        logic             valid;
        logic [PPN_W-1:0] ppn;
        logic             wp;
        logic             fault;
        logic             fault_wp;
        logic [VPN_W-1:0] vpn;
    } st_t;

    st_t s_d, s_q;

    logic             busy, accept, start;
    logic             lk_hit, lk_wp;
    logic [PPN_W-1:0] lk_ppn;
    logic             done, done_np, done_wp, done_store, ins_en;
    logic [PPN_W-1:0] done_ppn;
    logic [VPN_W-1:0] done_vpn;

    assign req_ready = !busy;
    assign accept    = req_valid && !busy;
    assign start     = accept && !lk_hit;

    tlbw_store #(
        .N_ENT(N_ENT),
        .VPN_W(VPN_W),
        .PPN_W(PPN_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (bp_we),
        .lk_vpn (req_vpn),
        .lk_hit (lk_hit),
        .lk_ppn (lk_ppn),
        .lk_wp  (lk_wp),
        .ins_en (ins_en),
        .ins_vpn(done_vpn),
        .ins_ppn(done_ppn),
        .ins_wp (done_wp)
    );

    tlbw_walker #(
        .VPN_W (VPN_W),
        .PPN_W (PPN_W),
        .ADDR_W(ADDR_W)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_vpn    (req_vpn),
        .start_store  (req_store),
        .base_ppn     (s_q.bp),
        .flush        (bp_we),
        .busy         (busy),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .done         (done),
        .done_np      (done_np),
        .done_ppn     (done_ppn),
        .done_wp      (done_wp),
        .done_vpn     (done_vpn),
        .done_store   (done_store),
        .ins_en       (ins_en)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (bp_we) begin
            s_d.bp = bp_ppn;
        end
        if (accept && lk_hit) begin
            s_d.valid    = 1'b1;
            s_d.ppn      = lk_ppn;
            s_d.wp       = lk_wp;
            s_d.fault    = req_store && lk_wp;
            s_d.fault_wp = req_store && lk_wp;
            s_d.vpn      = req_vpn;
        end else if (done) begin
            s_d.valid    = 1'b1;
            s_d.ppn      = done_np ? '0 : done_ppn;
            s_d.wp       = !done_np && done_wp;
            s_d.fault    = done_np || (done_store && done_wp);
            s_d.fault_wp = !done_np && done_store && done_wp;
            s_d.vpn      = done_vpn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_valid    = s_q.valid;
    assign rsp_ppn      = s_q.ppn;
    assign rsp_wp       = s_q.wp;
    assign rsp_fault    = s_q.fault;
    assign rsp_fault_wp = s_q.fault_wp;
    assign rsp_vpn      = s_q.vpn;

    // a hit never reaches memory
    assert_hit_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |-> !mem_req_valid);

    // a hit is answered on the following cycle
    assert_hit_answers_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> rsp_valid);

    // a protection fault always reports a protected page
    assert_wp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_wp) |-> (rsp_fault && rsp_wp));

    // refill only on a returned present entry
    assert_install_leaf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (mem_rsp_valid && mem_rsp_data[PTE_PRESENT]));
endmodule

// File: tb/tlbw_top_bench.sv
module tlbw_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bp_we = 1'b0;
    logic [19:0] bp_ppn = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [26:0] req_vpn = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_wp, rsp_fault, rsp_fault_wp;
    logic [19:0] rsp_ppn;
    logic [26:0] rsp_vpn;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mrsp_v = 1'b0;
    logic [63:0] mrsp_d = '0;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbw_top u_tlbw_top (
        .clk(clk), .rst_n(rst_n), .bp_we(bp_we), .bp_ppn(bp_ppn),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_store(req_store), .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn),
        .rsp_wp(rsp_wp), .rsp_fault(rsp_fault), .rsp_fault_wp(rsp_fault_wp),
        .rsp_vpn(rsp_vpn), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mrsp_v), .mem_rsp_data(mrsp_d)
    );

    // table contents as a pure function of the entry address
    function automatic logic [63:0] pte_fn(input logic [31:0] a);
        logic [19:0] t;
        logic [19:0] c;
        int i;
        logic v;
        logic w;
        t = a[31:12];
        i = int'(a[11:3]);
        w = 1'b0;
        case (t[19:18])
            2'd0: begin v = (i % 5) != 4; c = {2'b01, t[8:0], a[11:3]}; end
            2'd1: begin v = (i % 5) != 3; c = {2'b10, t[8:0], a[11:3]}; end
            default: begin
                v = (i % 6) != 5;
                c = {2'b11, t[8:0] ^ 9'h0a5, a[11:3]};
                w = (i % 3) == 0;
            end
        endcase
        return {34'd0, c, 8'd0, w, v};
    endfunction

    function automatic logic [26:0] pool(input int p);
        logic [8:0] a, b, c;
        a = 9'(p * 3 + 1);
        b = 9'(p * 2 + 1);
        c = 9'(p + 2);
        return {a, b, c};
    endfunction

    // fixed-latency memory
    int mcnt = 0;
    int reads = 0;
    logic [31:0] maddr = '0;
    logic [31:0] alog [4];
    logic overlap = 1'b0;

    always @(posedge clk) begin
        if (mrsp_v) mrsp_v <= 1'b0;
        if (mcnt > 0) begin
            if (mcnt == 1) begin
                mrsp_v <= 1'b1;
                mrsp_d <= pte_fn(maddr);
            end
            mcnt <= mcnt - 1;
        end
        if (rst_n && mem_req_valid) begin
            if (mcnt > 1) overlap <= 1'b1;
            maddr <= mem_req_addr;
            mcnt <= MEM_LAT - 1;
            alog[reads % 4] <= mem_req_addr;
            reads <= reads + 1;
        end
    end

    // bench model of the translation cache
    logic [26:0] mvpn [8];
    logic [19:0] mppn [8];
    logic        mwp  [8];
    logic        mval [8];
    int          mptr = 0;
    logic [19:0] base = '0;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) mval[i] = 1'b0;
    endtask

    task automatic bp_write(input logic [19:0] nb);
        @(negedge clk);
        bp_we = 1'b1;
        bp_ppn = nb;
        @(negedge clk);
        bp_we = 1'b0;
        model_clear();
        base = nb;
    endtask

    task automatic lookup(input logic [26:0] vpn, input logic st, input int bp_at,
                          input logic [19:0] bp_new);
        int hit_i, e_lvls, e_lat, cyc, rd0;
        logic e_hit, e_np, e_wp, e_fault, e_fwp, got;
        logic [19:0] e_ppn, tbl;
        logic [31:0] a, e_a0;
        logic [63:0] p;
        hit_i = -1;
        for (int i = 0; i < 8; i++) if (mval[i] && mvpn[i] == vpn) hit_i = i;
        e_hit = hit_i >= 0;
        e_np = 1'b0; e_lvls = 0; e_a0 = '0; e_wp = 1'b0; e_ppn = '0; p = '0;
        if (e_hit) begin
            e_ppn = mppn[hit_i];
            e_wp = mwp[hit_i];
        end else begin
            tbl = base;
            for (int l = 0; l < 3; l++) begin
                if (!e_np) begin
                    a = {tbl, 9'(vpn >> (18 - 9 * l)), 3'b000};
                    if (l == 0) e_a0 = a;
                    p = pte_fn(a);
                    e_lvls++;
                    if (!p[0]) e_np = 1'b1;
                    else tbl = p[29:10];
                end
            end
            if (!e_np) begin
                e_ppn = tbl;
                e_wp = p[1];
            end
        end
        e_fault = e_np || (st && e_wp);
        e_fwp = !e_np && st && e_wp;
        e_lat = 1 + e_lvls * MEM_LAT;
        rd0 = reads;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready while idle", longint'(req_ready), 1);
        req_valid = 1'b1;
        req_vpn = vpn;
        req_store = st;
        cyc = 0;
        got = 1'b0;
        while (!got && cyc < 1000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            req_valid = 1'b0;
            if (bp_at > 0) begin
                bp_we = (cyc == bp_at);
                if (cyc == bp_at) bp_ppn = bp_new;
            end
            if (cyc == 2 && !e_hit)
                chk(req_ready == 1'b0, "R9 stall during walk", longint'(req_ready), 0);
            if (rsp_valid) got = 1'b1;
        end
        bp_we = 1'b0;
        chk(cyc == e_lat, e_hit ? "R2 hit latency" : (e_np ? "R6 fault latency" : "R4 miss latency"),
            cyc, e_lat);
        chk(reads - rd0 == e_lvls, "R8 read count (hit/miss choice)", reads - rd0, e_lvls);
        if (!e_hit && e_lvls > 0)
            chk(alog[rd0 % 4] == e_a0, "R3 first read address", alog[rd0 % 4], e_a0);
        chk(rsp_fault == e_fault, "R7 fault flag", longint'(rsp_fault), longint'(e_fault));
        chk(rsp_fault_wp == e_fwp, "R7 protect cause", longint'(rsp_fault_wp), longint'(e_fwp));
        if (!e_np) begin
            chk(rsp_ppn == e_ppn, "R5 translated ppn", rsp_ppn, e_ppn);
            chk(rsp_wp == e_wp, "R5 protect bit", longint'(rsp_wp), longint'(e_wp));
        end else begin
            chk(rsp_vpn == vpn, "R6 faulting vpn", rsp_vpn, vpn);
        end
        if (bp_at > 0) begin
            model_clear();
            base = bp_new;
        end else if (!e_hit && !e_np) begin
            mvpn[mptr] = vpn;
            mppn[mptr] = e_ppn;
            mwp[mptr] = e_wp;
            mval[mptr] = 1'b1;
            mptr = (mptr + 1) % 8;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", longint'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", longint'(rsp_valid), 0);
        chk(mem_req_valid == 1'b0, "R1 no read after reset", longint'(mem_req_valid), 0);
        rst_n = 1'b1;
        bp_write(20'h00001);
        // small working set: second round hits, stores probe protection
        for (int k = 0; k < 12; k++) lookup(pool(k % 6), k >= 6, 0, '0);
        // larger working set drives round-robin eviction
        for (int k = 0; k < 52; k++) lookup(pool((k * 7) % 13), 1'(k % 2), 0, '0);
        // R10: new base flushes and redirects walks
        bp_write(20'h00002);
        lookup(pool(0), 1'b0, 0, '0);
        lookup(pool(0), 1'b1, 0, '0);
        // R11: base write in the middle of a walk
        lookup(pool(2), 1'b0, 60, 20'h00001);
        lookup(pool(2), 1'b0, 0, '0);
        lookup(pool(2), 1'b1, 0, '0);
        chk(overlap == 1'b0, "R9 single outstanding read", longint'(overlap), 0);
        summary();
        $finish;
    end
endmodule